// File: doc/BRIEF.md
# Dual-Address Two-Wire Memory Slave

This block is the slave side of a two-wire serial bus (I2C). It samples SCL and SDA with a fast system clock and turns bus transfers into single-cycle accesses on a synchronous memory port. Two register spaces sit behind it. The auxiliary space always answers one fixed device address. The main space answers a programmable device address, and only while an enable input is high. The block detects START, repeated START and STOP conditions. It shifts in device-address, pointer and data bytes, drives the acknowledge bit, and serves read bytes from a pointer. That pointer advances after every byte transferred.

The surrounding logic owns the two memories and the configuration. It supplies the programmable address and its enable, and it answers each read request with data one clock later. A `mem_space` line tells it which space an access belongs to. SDA is open-drain: the block only ever pulls the line low, through `sda_oe`.

Top module: `i2c_dual_slave`

## Requirements
- R1: A falling SDA edge while SCL is high (START or repeated START) restarts address reception from bit 0 in any state. A rising SDA edge while SCL is high (STOP) returns the block to idle with SDA released.
- R2: Bits are sampled on rising SCL edges, most significant first. In the first byte after a START, bits 7..1 are the 7-bit device address and bit 0 is the direction (0 = master writes, 1 = master reads).
- R3: Device address 7'h50 (address byte A0h/A1h) is always acknowledged. Its accesses carry `mem_space` = 0.
- R4: The device address `main_dev_addr` is acknowledged only while `main_dev_en` is 1, and its accesses carry `mem_space` = 1. If both spaces match the same address, the auxiliary space wins.
- R5: A device address that matches no active space gets no acknowledge. SDA stays released and no memory access occurs until the next START, so any read returns all ones.
- R6: In a write transfer, the second byte loads the pointer. Each following byte is written at the pointer, the pointer then increments by one, and every byte is acknowledged with a 0.
- R7: In a read transfer, bytes come from the pointer, most significant bit first. Each bit is driven after the preceding SCL falling edge. The pointer increments after each byte. Reading continues while the master acknowledges with 0; a 1 ends the read and releases SDA.
- R8: A repeated START followed by a read continues from the pointer set by the preceding write transfer, and a new read transfer continues where the previous one stopped.
- R9: SDA is driven only by asserting `sda_oe` (pull low), and `sda_oe` changes only while SCL is low.
- R10: `mem_req` is a one-cycle pulse. For a read (`mem_we` = 0), `mem_rdata` is expected to be valid in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low |
| main_dev_addr | input | 7 | Programmable 7-bit device address of the main space |
| main_dev_en | input | 1 | Enables the main-space address |
| mem_req | output | 1 | One-cycle memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_space | output | 1 | 0 = auxiliary space, 1 = main space |
| mem_addr | output | PTR_W | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read strobe |

## Verification
Every one of the 128 device addresses is sent, once with the main space enabled and once with it disabled. The acknowledge bit must appear for exactly the fixed address and, when enabled, the programmable one, which separates address decoding, MSB-first shifting and enable gating. Write bursts go to each space and are read back through repeated START. A fresh read then shows that the pointer carries over and that the spaces are routed apart. An unmatched address followed by data tells ignored traffic apart from accepted traffic. A configuration where the programmable address equals the fixed one exposes the priority between the spaces.

// File: rtl/i2c_dual_pkg.sv
// Shared types and constants for the dual-address two-wire slave.
package i2c_dual_pkg;

    // Protocol sequencer states.
    typedef enum logic [3:0] {
        ST_IDLE,     // waiting for START
        ST_DEV,      // shifting device address byte
        ST_REG,      // shifting pointer byte
        ST_WDATA,    // shifting write data bytes
        ST_SACK,     // slave drives acknowledge bit
        ST_TX,       // slave shifts out a read byte
        ST_TX_ACK,   // master acknowledge of a read byte
        ST_TX_WAIT,  // next read byte fetched, wait for SCL low
        ST_IGNORE    // not addressed, silent until START
    } slv_state_e;

    // Fixed 7-bit device address of the auxiliary space.
    localparam logic [6:0] AUX_DEV_ADDR = 7'h50;

    // Space selector values on the memory port.
    localparam logic SPACE_AUX  = 1'b0;
    localparam logic SPACE_MAIN = 1'b1;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizer for one asynchronous bus line.
// Assumes: STAGES >= 2; the line idles high, so the flops reset to 1.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
        end
    end

    assign line_o = chain[STAGES-1];

endmodule

// File: rtl/i2c_bus_events.sv
// Turns synchronized SCL/SDA levels into single-cycle bus events.
// Assumes: inputs are already synchronized to clk.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic scl_p;
    logic sda_p;

    // Remember the previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Edges of SCL, and SDA edges while SCL stays high.
    always_comb begin
        scl_rise = scl_s & ~scl_p;
        scl_fall = ~scl_s & scl_p;
        start_ev = scl_s & scl_p & sda_p & ~sda_s;
        stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/i2c_addr_decode.sv
// Decodes a device-address byte against the fixed and programmable addresses.
// Assumes: the fixed space has priority when both addresses are equal.
module i2c_addr_decode #(
    parameter logic [6:0] AUX_ADDR = i2c_dual_pkg::AUX_DEV_ADDR
) (
    input  logic [7:0] addr_byte,
    input  logic [6:0] main_addr,
    input  logic       main_en,
    output logic       hit,
    output logic       space,
    output logic       rw
);

    logic aux_hit;
    logic main_hit;

    // Compare the upper seven bits against each active address.
    always_comb begin
        aux_hit  = (addr_byte[7:1] == AUX_ADDR);
        main_hit = main_en && (addr_byte[7:1] == main_addr);
        hit      = aux_hit | main_hit;
        space    = aux_hit ? i2c_dual_pkg::SPACE_AUX : i2c_dual_pkg::SPACE_MAIN;
        rw       = addr_byte[0];
    end

endmodule

// File: rtl/i2c_dual_slave.sv
// Two-wire bus slave serving two memory spaces through a synchronous port.
// Assumes: clk runs at least 16 times faster than SCL; main_dev_addr and
// main_dev_en are static while a transfer is in progress; PTR_W <= 8.
module i2c_dual_slave #(
    parameter int         PTR_W       = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] AUX_ADDR    = i2c_dual_pkg::AUX_DEV_ADDR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [6:0]       main_dev_addr,
    input  logic             main_dev_en,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_space,
    output logic [PTR_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata
);
    import i2c_dual_pkg::*;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_ev, stop_ev;

    slv_state_e        state, ack_next;
    logic              ack_on;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, full_byte;
    logic [PTR_W-1:0]  ptr;
    logic              space_q;
    logic [1:0]        rd_pipe;
    logic              dec_hit, dec_space, dec_rw;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_s)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_s)
    );

    i2c_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    // The byte completed by the bit arriving on this rising edge.
    assign full_byte = {rx_sh[BYTE_W-2:0], sda_s};

    i2c_addr_decode #(.AUX_ADDR(AUX_ADDR)) u_decode (
        .addr_byte(full_byte), .main_addr(main_dev_addr), .main_en(main_dev_en),
        .hit(dec_hit), .space(dec_space), .rw(dec_rw)
    );

    // Protocol sequencer, pointer and memory port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ack_next  <= ST_IDLE;
            ack_on    <= 1'b0;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            ptr       <= '0;
            space_q   <= SPACE_AUX;
            rd_pipe   <= '0;
            sda_oe    <= 1'b0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_space <= SPACE_AUX;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            rd_pipe <= {rd_pipe[0], 1'b0};
            if (rd_pipe[1]) begin
                tx_sh <= mem_rdata;
            end
            if (start_ev) begin
                state  <= ST_DEV;
                cnt    <= '0;
                ack_on <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_ev) begin
                state  <= ST_IDLE;
                ack_on <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_REG, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh <= full_byte;
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                if (state == ST_DEV) begin
                                    if (dec_hit) begin
                                        space_q  <= dec_space;
                                        state    <= ST_SACK;
                                        ack_next <= dec_rw ? ST_TX : ST_REG;
                                        if (dec_rw) begin
                                            mem_req    <= 1'b1;
                                            mem_space  <= dec_space;
                                            mem_addr   <= ptr;
                                            rd_pipe[0] <= 1'b1;
                                        end
                                    end else begin
                                        state <= ST_IGNORE;
                                    end
                                end else if (state == ST_REG) begin
                                    ptr      <= full_byte[PTR_W-1:0];
                                    state    <= ST_SACK;
                                    ack_next <= ST_WDATA;
                                end else begin
                                    mem_req   <= 1'b1;
                                    mem_we    <= 1'b1;
                                    mem_space <= space_q;
                                    mem_addr  <= ptr;
                                    mem_wdata <= full_byte;
                                    ptr       <= ptr + 1'b1;
                                    state     <= ST_SACK;
                                    ack_next  <= ST_WDATA;
                                end
                            end
                        end
                    end
                    ST_SACK: begin
                        if (scl_fall) begin
                            if (!ack_on) begin
                                sda_oe <= 1'b1;
                                ack_on <= 1'b1;
                            end else begin
                                ack_on <= 1'b0;
                                state  <= ack_next;
                                cnt    <= '0;
                                sda_oe <= (ack_next == ST_TX) ? ~tx_sh[BYTE_W-1] : 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                state <= ST_TX_ACK;
                            end
                        end
                        if (scl_fall) begin
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx_sh[BYTE_W-2];
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                        end
                        if (scl_rise) begin
                            ptr <= ptr + 1'b1;
                            if (!sda_s) begin
                                mem_req    <= 1'b1;
                                mem_space  <= space_q;
                                mem_addr   <= ptr + 1'b1;
                                rd_pipe[0] <= 1'b1;
                                state      <= ST_TX_WAIT;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_TX_WAIT: begin
                        if (scl_fall) begin
                            state  <= ST_TX;
                            cnt    <= '0;
                            sda_oe <= ~tx_sh[BYTE_W-1];
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !scl_s) else $error("sda_oe moved while SCL high"); // R9
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req) else $error("mem_req longer than one cycle"); // R10
    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_IGNORE) |-> (!sda_oe && !mem_req)) else $error("activity while ignoring"); // R5
    AST_MAIN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_space == SPACE_MAIN) |-> main_dev_en) else $error("main access while disabled"); // R4
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) stop_ev |=> (!sda_oe && state == ST_IDLE)) else $error("STOP did not release"); // R1
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) start_ev |=> (state == ST_DEV && cnt == '0)) else $error("START did not restart"); // R1
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we) |-> (ptr == PTR_W'(mem_addr + 1'b1))) else $error("pointer did not advance"); // R6

endmodule

// File: tb/tb_i2c_dual_slave.sv
module tb_i2c_dual_slave;

    localparam int HP = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [6:0] main_dev_addr;
    logic       main_dev_en;
    logic       mem_req, mem_we, mem_space;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    wire        sda_bus = sda_m & ~sda_oe;

    logic [7:0] aux_mem  [256];
    logic [7:0] main_mem [256];
    logic [7:0] exp_aux  [256];
    logic [7:0] exp_main [256];

    int errors = 0;
    int checks = 0;
    int req_viol = 0;
    int oe_viol = 0;
    int quiet_viol = 0;
    logic watch_quiet = 1'b0;
    logic done = 1'b0;

    i2c_dual_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .main_dev_addr(main_dev_addr), .main_dev_en(main_dev_en),
        .mem_req(mem_req), .mem_we(mem_we), .mem_space(mem_space),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Bench memories: write on strobe, read data one cycle later.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                if (mem_space) main_mem[mem_addr] <= mem_wdata;
                else           aux_mem[mem_addr]  <= mem_wdata;
            end else begin
                mem_rdata <= mem_space ? main_mem[mem_addr] : aux_mem[mem_addr];
            end
        end
    end

    // Port monitors for strobe width, SDA timing and silence.
    logic req_p = 1'b0;
    logic oe_p = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && req_p) req_viol++;
            if ((sda_oe != oe_p) && scl_m) oe_viol++;
            if (watch_quiet && (sda_oe || mem_req)) quiet_viol++;
        end
        req_p = mem_req;
        oe_p  = sda_oe;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
        end
        sda_m = 1'b1; hp(); scl_m = 1'b1;
        repeat (HP / 2) @(negedge clk);
        ack = sda_bus;
        repeat (HP / 2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic rx_byte(output logic [7:0] b, input logic nack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp(); scl_m = 1'b1;
            repeat (HP / 2) @(negedge clk);
            b[i] = sda_bus;
            repeat (HP / 2) @(negedge clk);
            scl_m = 1'b0;
        end
        sda_m = nack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; sda_m = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rb;
        for (int i = 0; i < 256; i++) begin
            aux_mem[i]  = 8'(i + 8'h40);
            main_mem[i] = 8'(i) ^ 8'h96;
            exp_aux[i]  = aux_mem[i];
            exp_main[i] = main_mem[i];
        end
        main_dev_addr = 7'h1E;
        main_dev_en   = 1'b0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 reset sda_oe", int'(sda_oe), 0);
        check("R10 reset mem_req", int'(mem_req), 0);

        // R2 R3 R4: sweep all device addresses, main space off then on.
        for (int en = 0; en < 2; en++) begin
            main_dev_en = en[0];
            for (int a = 0; a < 128; a++) begin
                bus_start();
                tx_byte({a[6:0], 1'b0}, ack);
                bus_stop();
                check($sformatf("R2/R3/R4 addr %0h en %0d ack", a, en), int'(ack),
                      ((a == 8'h50) || (en == 1 && a == 8'h1E)) ? 0 : 1);
            end
        end

        // R6: write burst into the auxiliary space.
        bus_start();
        tx_byte(8'hA0, ack); check("R3 aux write ack", int'(ack), 0);
        tx_byte(8'h10, ack); check("R6 pointer ack", int'(ack), 0);
        for (int k = 0; k < 3; k++) begin
            tx_byte(8'(8'h11 * (k + 1)), ack);
            check("R6 data ack", int'(ack), 0);
            exp_aux[8'h10 + k] = 8'(8'h11 * (k + 1));
        end
        bus_stop();
        for (int k = 0; k < 3; k++) begin
            check("R6 aux stored", int'(aux_mem[8'h10 + k]), int'(exp_aux[8'h10 + k]));
            check("R3 main untouched", int'(main_mem[8'h10 + k]), int'(exp_main[8'h10 + k]));
        end

        // R4: write into the main space.
        bus_start();
        tx_byte({7'h1E, 1'b0}, ack); check("R4 main write ack", int'(ack), 0);
        tx_byte(8'h10, ack);
        tx_byte(8'hA5, ack); exp_main[8'h10] = 8'hA5;
        tx_byte(8'h5A, ack); exp_main[8'h11] = 8'h5A;
        bus_stop();
        check("R4 main stored 0", int'(main_mem[8'h10]), 8'hA5);
        check("R4 main stored 1", int'(main_mem[8'h11]), 8'h5A);
        check("R4 aux untouched", int'(aux_mem[8'h10]), int'(exp_aux[8'h10]));

        // R7 R8: pointer set by write, repeated START, burst read.
        bus_start();
        tx_byte(8'hA0, ack);
        tx_byte(8'h10, ack);
        bus_start();
        tx_byte(8'hA1, ack); check("R8 read ack after restart", int'(ack), 0);
        for (int k = 0; k < 3; k++) begin
            rx_byte(rb, (k == 2));
            check($sformatf("R7 aux read %0d", k), int'(rb), int'(exp_aux[8'h10 + k]));
        end
        bus_stop();
        check("R7 released after NACK", int'(sda_oe), 0);

        // R8: main read, then a fresh read continues from the pointer.
        bus_start();
        tx_byte({7'h1E, 1'b0}, ack);
        tx_byte(8'h11, ack);
        bus_start();
        tx_byte({7'h1E, 1'b1}, ack);
        rx_byte(rb, 1'b1);
        check("R8 main read at pointer", int'(rb), int'(exp_main[8'h11]));
        bus_stop();
        bus_start();
        tx_byte({7'h1E, 1'b1}, ack);
        rx_byte(rb, 1'b0);
        check("R8 continued read 0", int'(rb), int'(exp_main[8'h12]));
        rx_byte(rb, 1'b1);
        check("R8 continued read 1", int'(rb), int'(exp_main[8'h13]));
        bus_stop();

        // R5: unmatched address followed by data, then an unmatched read.
        watch_quiet = 1'b1;
        bus_start();
        tx_byte(8'h84, ack); check("R5 no ack addr", int'(ack), 1);
        tx_byte(8'h10, ack); check("R5 no ack ptr", int'(ack), 1);
        tx_byte(8'h77, ack); check("R5 no ack data", int'(ack), 1);
        bus_stop();
        bus_start();
        tx_byte(8'h85, ack);
        rx_byte(rb, 1'b1);
        check("R5 unmatched read", int'(rb), 8'hFF);
        bus_stop();
        watch_quiet = 1'b0;
        check("R5 silent while ignored", quiet_viol, 0);
        check("R5 aux unchanged", int'(aux_mem[8'h10]), int'(exp_aux[8'h10]));
        check("R5 main unchanged", int'(main_mem[8'h10]), int'(exp_main[8'h10]));

        // R4: disabled main address does not store.
        main_dev_en = 1'b0;
        bus_start();
        tx_byte({7'h1E, 1'b0}, ack); check("R4 disabled no ack", int'(ack), 1);
        tx_byte(8'h30, ack);
        tx_byte(8'h99, ack);
        bus_stop();
        check("R4 disabled no store", int'(main_mem[8'h30]), int'(exp_main[8'h30]));

        // R4: equal addresses, auxiliary space has priority.
        main_dev_addr = 7'h50;
        main_dev_en   = 1'b1;
        bus_start();
        tx_byte(8'hA0, ack);
        tx_byte(8'h20, ack);
        tx_byte(8'hC3, ack);
        bus_stop();
        check("R4 priority aux stored", int'(aux_mem[8'h20]), 8'hC3);
        check("R4 priority main untouched", int'(main_mem[8'h20]), int'(exp_main[8'h20]));

        check("R10 strobe single cycle", req_viol, 0);
        check("R9 sda_oe only with SCL low", oe_viol, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule